// File: doc/BRIEF.md
# Serial Control Slave with Dual Status Readback

This block is the two-wire serial (I2C-compatible) target port of a supply-regulator controller. It samples SCL and SDA with the system clock and passes both through a short synchroniser and glitch filter. It pulls SDA low through an open-drain enable. A write transaction moves exactly one byte. The top two bits of that byte pick one of four register slots, and the low six bits are the payload. Only slot 0 (output level and enable) and slot 2 (tone control) keep their payload.

A read transaction streams status bytes taken from two external status words. The stream always opens with the first word. Each acknowledge from the master flips to the other word. The status source sees a one-cycle strobe when the master's acknowledge bit is clocked in for each byte it reads, so it can reload or clear latched flags. The port also gives a one-cycle pulse when it is addressed for reading and a one-cycle pulse when a write byte is accepted.

Top module: `pwrctl_i2c_slave`

## Requirements
- R1: The port answers only to the 7-bit target address {00010, addr_sel[1:0]}, received MSB first and followed by the direction bit (1 = read). A non-matching address gets no acknowledge, and the rest of that transaction is ignored.
- R2: After a matching address, and after an accepted write byte, the port holds SDA low for the whole ninth SCL clock.
- R3: In a write byte, bits 7:6 are the slot number and bits 5:0 are the payload. Slot 00 loads `ctrl_volt` and slot 10 loads `ctrl_tone`. The register outputs change only in the cycle after a `wr_done` pulse.
- R4: A byte for slot 01 or 11 is acknowledged and reported on `wr_done`, but neither register output changes.
- R5: Only the first byte after a write address is accepted. Any later byte before STOP is not acknowledged and changes no register.
- R6: Every read transaction starts with `stat1_i`, and its bits are sent MSB first.
- R7: A master acknowledge (SDA low on the ninth clock) switches the next byte to the other status word, giving 1, 2, 1, and so on. A master no-acknowledge makes the port release SDA and wait for STOP.
- R8: On the ninth SCL rising edge of every read byte, `rd_strobe` pulses for one cycle and `rd_strobe_sel` shows which word was just sent (0 = `stat1_i`, 1 = `stat2_i`). The strobe, `wr_done` and `rd_addr_hit` are never high together.
- R9: `rd_addr_hit` pulses for one cycle when a matching address arrives with the read bit set.
- R10: A START or STOP at any point abandons the transfer in progress. A repeated START begins a new address phase at once.
- R11: After reset both register outputs are 0, SDA is released and all pulses are low.
- R12: A pulse on SCL that lasts a single system clock is filtered out and does not count as a clock.
- R13: `wr_done` is a one-cycle pulse, issued once for each acknowledged write byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 2 | Low two bits of the target address |
| stat1_i | input | 8 | First status word |
| stat2_i | input | 8 | Second status word |
| ctrl_volt | output | 6 | Payload of slot 00 |
| ctrl_tone | output | 6 | Payload of slot 10 |
| rd_strobe | output | 1 | Pulse at the ninth clock of each read byte |
| rd_strobe_sel | output | 1 | Word sent in the byte just strobed |
| wr_done | output | 1 | Pulse for each accepted write byte |
| rd_addr_hit | output | 1 | Pulse when addressed for reading |

## Verification
The strobe for a finished read byte and the choice of the next status word are made on the same filtered SCL rising edge. A wrong choice would therefore show up either as a misattributed strobe or as a wrong following byte. The bench provokes this with a read of three bytes (acknowledge, acknowledge, no-acknowledge), using two status words whose values cannot be confused. It then judges the received byte values together with the recorded order of strobe selections and the strobe count. A final check confirms that the line is released after the no-acknowledge.

// File: rtl/pwrctl_i2c_pkg.sv
package pwrctl_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP
    } i2c_state_e;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [4:0] DEV_ADDR_HI = 5'b00010;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            hist_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                line_o <= 1'b1;
            else if (~|hist_q)
                line_o <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import pwrctl_i2c_pkg::*;
#(
    parameter int SUB_W = 2,
    parameter int DW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [1:0]       addr_sel,
    input  logic [BYTE_W-1:0] stat1_i,
    input  logic [BYTE_W-1:0] stat2_i,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [SUB_W-1:0] wr_sub,
    output logic [DW-1:0]    wr_data,
    output logic             rd_strobe,
    output logic             rd_strobe_sel,
    output logic             rd_addr_hit
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    i2c_state_e        state_q, state_d;
    logic              scl_q, sda_q;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] shreg_q, tx_q;
    logic              rw_q, sel_q, mack_q;
    logic              byte_end, addr_match, shifting;

    // bus event detection on filtered lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise   = scl_f & ~scl_q;
    assign scl_fall   = ~scl_f & scl_q;
    assign start_ev   = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev    = scl_f & scl_q & ~sda_q & sda_f;
    assign byte_end   = scl_fall && (bitcnt_q == LAST_BIT);
    assign addr_match = (shreg_q[7:1] == {DEV_ADDR_HI, addr_sel});
    assign shifting   = (state_q == ST_ADDR) || (state_q == ST_WR_BYTE) ||
                        (state_q == ST_RD_BYTE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_end) state_d = addr_match ? ST_ADDR_ACK : ST_WAIT_STOP;
                ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:   if (byte_end) state_d = ST_WR_ACK;
                ST_WR_ACK:    if (scl_fall) state_d = ST_WAIT_STOP;
                ST_RD_BYTE:   if (byte_end) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_d = mack_q ? ST_RD_BYTE : ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath: bit counter, shifters, read bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            tx_q     <= '0;
            rw_q     <= 1'b0;
            sel_q    <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            if (start_ev || stop_ev || (state_d != state_q))
                bitcnt_q <= '0;
            else if (scl_rise && shifting)
                bitcnt_q <= bitcnt_q + 1'b1;

            if (start_ev)
                shreg_q <= '0;
            else if (scl_rise && ((state_q == ST_ADDR) || (state_q == ST_WR_BYTE)))
                shreg_q <= {shreg_q[BYTE_W-2:0], sda_f};

            if (state_q == ST_ADDR && state_d == ST_ADDR_ACK)
                rw_q <= shreg_q[0];

            if (state_q == ST_ADDR_ACK && state_d == ST_RD_BYTE) begin
                tx_q  <= stat1_i;
                sel_q <= 1'b0;
            end else if (state_q == ST_RD_ACK && state_d == ST_RD_BYTE) begin
                tx_q <= sel_q ? stat2_i : stat1_i;
            end else if (state_q == ST_RD_BYTE && state_d == ST_RD_BYTE && scl_fall) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end

            if (state_q == ST_RD_ACK && scl_rise) begin
                mack_q <= ~sda_f;
                if (!sda_f)
                    sel_q <= ~sel_q;
            end
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en         <= 1'b0;
            wr_sub        <= '0;
            wr_data       <= '0;
            rd_strobe     <= 1'b0;
            rd_strobe_sel <= 1'b0;
            rd_addr_hit   <= 1'b0;
        end else begin
            wr_en       <= (state_q == ST_WR_BYTE) && (state_d == ST_WR_ACK);
            rd_addr_hit <= (state_q == ST_ADDR) && (state_d == ST_ADDR_ACK) && shreg_q[0];
            rd_strobe   <= (state_q == ST_RD_ACK) && scl_rise;
            if ((state_q == ST_RD_ACK) && scl_rise)
                rd_strobe_sel <= sel_q;
            if ((state_q == ST_WR_BYTE) && (state_d == ST_WR_ACK)) begin
                wr_sub  <= shreg_q[BYTE_W-1 -: SUB_W];
                wr_data <= shreg_q[DW-1:0];
            end
        end
    end

    // open-drain drive decided by state
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_q[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
    parameter int                       DW       = 6,
    parameter int                       SUB_W    = 2,
    parameter int                       NSLOT    = 2,
    parameter logic [NSLOT*SUB_W-1:0]   SLOT_MAP = 4'b10_00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SUB_W-1:0]          wr_sub,
    input  logic [DW-1:0]             wr_data,
    output logic [NSLOT-1:0][DW-1:0]  slot_o
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [SUB_W-1:0] MY_SUB = SLOT_MAP[g*SUB_W +: SUB_W];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_o[g] <= '0;
            else if (wr_en && (wr_sub == MY_SUB))
                slot_o[g] <= wr_data;
        end
    end

endmodule

// File: rtl/pwrctl_i2c_slave.sv
module pwrctl_i2c_slave
    import pwrctl_i2c_pkg::*;
#(
    parameter int FILT_LEN = 2,
    parameter int CTRL_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        addr_sel,
    input  logic [7:0]        stat1_i,
    input  logic [7:0]        stat2_i,
    output logic [CTRL_W-1:0] ctrl_volt,
    output logic [CTRL_W-1:0] ctrl_tone,
    output logic              rd_strobe,
    output logic              rd_strobe_sel,
    output logic              wr_done,
    output logic              rd_addr_hit
);

    localparam int SUB_W = BYTE_W - CTRL_W;
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_lines, filt_lines;
    logic [SUB_W-1:0] wr_sub;
    logic [CTRL_W-1:0] wr_data;
    logic [1:0][CTRL_W-1:0] slots;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_flt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2c_xfer_fsm #(.SUB_W(SUB_W), .DW(CTRL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_f         (filt_lines[0]),
        .sda_f         (filt_lines[1]),
        .addr_sel      (addr_sel),
        .stat1_i       (stat1_i),
        .stat2_i       (stat2_i),
        .sda_oe        (sda_oe),
        .wr_en         (wr_done),
        .wr_sub        (wr_sub),
        .wr_data       (wr_data),
        .rd_strobe     (rd_strobe),
        .rd_strobe_sel (rd_strobe_sel),
        .rd_addr_hit   (rd_addr_hit)
    );

    ctrl_regfile #(
        .DW       (CTRL_W),
        .SUB_W    (SUB_W),
        .NSLOT    (2),
        .SLOT_MAP ({2'b10, 2'b00})
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_done),
        .wr_sub  (wr_sub),
        .wr_data (wr_data),
        .slot_o  (slots)
    );

    assign ctrl_volt = slots[0];
    assign ctrl_tone = slots[1];

endmodule

// File: rtl/pwrctl_i2c_slave_chk.sv
module pwrctl_i2c_slave_chk #(
    parameter int CTRL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [CTRL_W-1:0] ctrl_volt,
    input logic [CTRL_W-1:0] ctrl_tone,
    input logic              rd_strobe,
    input logic              wr_done,
    input logic              rd_addr_hit
);

    a_r13_wr_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_strobe, wr_done, rd_addr_hit}));

    a_r9_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_hit |=> !rd_addr_hit);

    a_r3_volt_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_volt) |-> $past(wr_done));

    a_r3_tone_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_tone) |-> $past(wr_done));

    a_r2_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

endmodule

bind pwrctl_i2c_slave pwrctl_i2c_slave_chk #(.CTRL_W(CTRL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .ctrl_volt   (ctrl_volt),
    .ctrl_tone   (ctrl_tone),
    .rd_strobe   (rd_strobe),
    .wr_done     (wr_done),
    .rd_addr_hit (rd_addr_hit)
);

// File: tb/pwrctl_i2c_slave_test.sv
module pwrctl_i2c_slave_test;

    localparam int Q = 25;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       scl_drv;
    logic       m_sda_low;
    logic [1:0] addr_sel;
    logic [7:0] stat1, stat2;
    logic       sda_oe;
    logic [5:0] ctrl_volt, ctrl_tone;
    logic       rd_strobe, rd_strobe_sel, wr_done, rd_addr_hit;
    logic       sda_line;

    assign sda_line = ~(m_sda_low | sda_oe);

    pwrctl_i2c_slave uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_drv),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .addr_sel      (addr_sel),
        .stat1_i       (stat1),
        .stat2_i       (stat2),
        .ctrl_volt     (ctrl_volt),
        .ctrl_tone     (ctrl_tone),
        .rd_strobe     (rd_strobe),
        .rd_strobe_sel (rd_strobe_sel),
        .wr_done       (wr_done),
        .rd_addr_hit   (rd_addr_hit)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int strobe_cnt = 0;
    int wr_cnt = 0;
    int hit_cnt = 0;
    logic [7:0] sel_hist = '0;

    always @(posedge clk) begin
        if (rd_strobe) begin
            strobe_cnt <= strobe_cnt + 1;
            sel_hist   <= {sel_hist[6:0], rd_strobe_sel};
        end
        if (wr_done)     wr_cnt  <= wr_cnt + 1;
        if (rd_addr_hit) hit_cnt <= hit_cnt + 1;
    end

    // {addr_sel, write byte, expected volt, expected tone}
    localparam logic [21:0] WVEC [0:6] = '{
        {2'd0, 8'h25, 6'h25, 6'h00},
        {2'd1, 8'h83, 6'h25, 6'h03},
        {2'd2, 8'h7F, 6'h25, 6'h03},
        {2'd3, 8'hC9, 6'h25, 6'h03},
        {2'd3, 8'h00, 6'h00, 6'h03},
        {2'd0, 8'hBE, 6'h00, 6'h3E},
        {2'd2, 8'h3A, 6'h3A, 6'h3E}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq();
        scl_drv = 1'b1;   wq();
        m_sda_low = 1'b1; wq();
        scl_drv = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq();
        scl_drv = 1'b1;   wq();
        m_sda_low = 1'b0; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda_low = ~b[i];
            if (glitch && i == 4) begin
                wq(12);
                scl_drv = 1'b1; wq(1);
                scl_drv = 1'b0; wq(Q - 13);
            end else begin
                wq();
            end
            scl_drv = 1'b1; wq(2 * Q);
            scl_drv = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
        send_bits(b, 8, glitch);
        m_sda_low = 1'b0; wq();
        scl_drv = 1'b1;   wq();
        ack = ~sda_line;  wq();
        scl_drv = 1'b0;   wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_drv = 1'b1; wq();
            b[i] = sda_line; wq();
            scl_drv = 1'b0; wq();
        end
        m_sda_low = give_ack; wq();
        scl_drv = 1'b1; wq(2 * Q);
        scl_drv = 1'b0; wq();
        m_sda_low = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a_ack, d_ack;
        logic [7:0] rb;
        int base;
        rst_n = 1'b0; scl_drv = 1'b1; m_sda_low = 1'b0;
        addr_sel = 2'd0; stat1 = 8'hA5; stat2 = 8'h3C;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R11 reset state
        chk(ctrl_volt == 6'h00, "R11 volt reset", 32'(ctrl_volt), 0);
        chk(ctrl_tone == 6'h00, "R11 tone reset", 32'(ctrl_tone), 0);
        chk(sda_oe == 1'b0 && !rd_strobe && !wr_done && !rd_addr_hit, "R11 outputs idle", 32'(sda_oe), 0);

        // table walk: R1 R2 R3 R4 R13
        for (int v = 0; v < 7; v++) begin
            logic [21:0] e;
            e = WVEC[v];
            addr_sel = e[21:20];
            base = wr_cnt;
            wq(5);
            bus_start();
            send_byte({5'b00010, e[21:20], 1'b0}, 1'b0, a_ack);
            send_byte(e[19:12], 1'b0, d_ack);
            bus_stop();
            wq(10);
            chk(a_ack == 1'b1, "R1 address ack", 32'(a_ack), 1);
            chk(d_ack == 1'b1, "R2/R4 data ack", 32'(d_ack), 1);
            chk(ctrl_volt == e[11:6], "R3/R4 volt slot", 32'(ctrl_volt), 32'(e[11:6]));
            chk(ctrl_tone == e[5:0], "R3/R4 tone slot", 32'(ctrl_tone), 32'(e[5:0]));
            chk(wr_cnt == base + 1, "R13 one wr_done per byte", 32'(wr_cnt), 32'(base + 1));
        end

        // R1 wrong address
        addr_sel = 2'd1;
        base = wr_cnt;
        bus_start();
        send_byte({5'b00010, 2'd2, 1'b0}, 1'b0, a_ack);
        send_byte(8'h15, 1'b0, d_ack);
        bus_stop();
        wq(10);
        chk(a_ack == 1'b0, "R1 foreign address nak", 32'(a_ack), 0);
        chk(d_ack == 1'b0, "R1 foreign data ignored", 32'(d_ack), 0);
        chk(ctrl_volt == 6'h3A && wr_cnt == base, "R1 regs untouched", 32'(ctrl_volt), 32'h3A);

        // R5 second byte refused
        addr_sel = 2'd0;
        bus_start();
        send_byte(8'b0001000_0, 1'b0, a_ack);
        send_byte(8'h11, 1'b0, d_ack);
        send_byte(8'h05, 1'b0, d_ack);
        bus_stop();
        wq(10);
        chk(d_ack == 1'b0, "R5 extra byte nak", 32'(d_ack), 0);
        chk(ctrl_volt == 6'h11, "R5 only first byte kept", 32'(ctrl_volt), 32'h11);

        // R6 R7 R8 R9 multi-byte read
        base = strobe_cnt;
        bus_start();
        send_byte(8'b0001000_1, 1'b0, a_ack);
        chk(hit_cnt == 1, "R9 read address pulse", 32'(hit_cnt), 1);
        recv_byte(1'b1, rb);
        chk(rb == 8'hA5, "R6 first byte stat1", 32'(rb), 32'hA5);
        recv_byte(1'b1, rb);
        chk(rb == 8'h3C, "R7 second byte stat2", 32'(rb), 32'h3C);
        recv_byte(1'b0, rb);
        chk(rb == 8'hA5, "R7 third byte stat1", 32'(rb), 32'hA5);
        wq(10);
        chk(sda_oe == 1'b0 && sda_line == 1'b1, "R7 released after nak", 32'(sda_oe), 0);
        bus_stop();
        wq(5);
        chk(strobe_cnt == base + 3, "R8 strobe count", 32'(strobe_cnt), 32'(base + 3));
        chk(sel_hist[2:0] == 3'b010, "R8 strobe order", 32'(sel_hist[2:0]), 32'b010);

        // R6 new read restarts at stat1
        bus_start();
        send_byte(8'b0001000_1, 1'b0, a_ack);
        recv_byte(1'b0, rb);
        bus_stop();
        chk(rb == 8'hA5, "R6 restart at stat1", 32'(rb), 32'hA5);
        chk(hit_cnt == 2, "R9 second read pulse", 32'(hit_cnt), 2);

        // R10 STOP mid-byte aborts
        bus_start();
        send_byte(8'b0001000_0, 1'b0, a_ack);
        send_bits(8'h2A, 4, 1'b0);
        bus_stop();
        wq(10);
        chk(ctrl_volt == 6'h11, "R10 abort keeps regs", 32'(ctrl_volt), 32'h11);
        bus_start();
        send_byte(8'b0001000_0, 1'b0, a_ack);
        send_byte(8'h2A, 1'b0, d_ack);
        bus_stop();
        wq(10);
        chk(ctrl_volt == 6'h2A, "R10 recovery after abort", 32'(ctrl_volt), 32'h2A);

        // R10 repeated start turns a write into a read
        bus_start();
        send_byte(8'b0001000_0, 1'b0, a_ack);
        bus_start();
        send_byte(8'b0001000_1, 1'b0, a_ack);
        chk(a_ack == 1'b1, "R10 repeated start ack", 32'(a_ack), 1);
        recv_byte(1'b0, rb);
        bus_stop();
        chk(rb == 8'hA5, "R10 repeated start read", 32'(rb), 32'hA5);

        // R12 one-clock glitch on SCL
        bus_start();
        send_byte(8'b0001000_0, 1'b0, a_ack);
        send_byte(8'h07, 1'b1, d_ack);
        bus_stop();
        wq(10);
        chk(d_ack == 1'b1, "R12 glitch ack", 32'(d_ack), 1);
        chk(ctrl_volt == 6'h07, "R12 glitch filtered", 32'(ctrl_volt), 32'h07);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule